// File: doc/BRIEF.md
# Core Idle Power Sequencer

This block walks a single processor core through a low-power episode and back. A request that carries a state index moves the core out of normal execution into a preparation phase, then into an entry phase that cannot be cancelled, then into an idle phase of unbounded length, and finally through an exit phase back to execution. A wake event seen during preparation cancels the request at once. A wake event seen after that point is acted on only once the core has reached idle.

Each state index selects a set of configuration fields. These are a minimum entry dwell, a minimum exit dwell, a flag that chooses between clock-gated retention and full power collapse, and a flag marking states in which the local timer is lost. Retention states only gate the core clock. Power-collapse states have extra steps: they wait for the cache flush before power is removed, wait for the power switch to acknowledge, restore power on exit, wait for the caches to report ready, and then release the core through a one-cycle warm-boot strobe. A request index that points past the configured states falls back to state 0, the shallowest clock-gate state.

Top module: `cidle_seq`

## Requirements
- R1: During and right after synchronous reset, `phase` is 0 (run), `pwr_en` is 1, and `clk_gate`, `core_rst`, `warm_boot` and `timer_lost` are 0.
- R2: The phase codes are run=0, prepare=1, enter=2, idle=3, exit=4. An `idle_req` sampled in run moves the phase to prepare on the next cycle. Phases then follow the order prepare, enter, idle, exit, run.
- R3: A `wake` sampled in prepare returns the phase to run on the next cycle. In that case power is never removed, `timer_lost` is never set and no warm boot is issued.
- R4: Enter leaves only to idle. A `wake` held through enter does not shorten it, and is acted on in the first idle cycle.
- R5: Idle lasts until `wake` is sampled in an idle cycle, and exit follows on the next cycle. This means idle lasts at least one cycle.
- R6: For a retention state, enter lasts exactly max(E,1) cycles and exit exactly max(X,1) cycles. E and X are the state's fields `cfg_entry_cyc[i*CW +: CW]` and `cfg_exit_cyc[i*CW +: CW]`. For a collapse state, each phase lasts at least that long and also until its handshake is met.
- R7: A retention state (`cfg_collapse[i]`=0) spends exactly one cycle in prepare. `clk_gate` is 1 during enter, idle and exit, `pwr_en` stays 1 and `warm_boot` stays 0.
- R8: A collapse state (`cfg_collapse[i]`=1) stays in prepare until `flush_done` is sampled high. `pwr_en` is 0 only during enter and idle, and never falls unless `flush_done` was high in the cycle before.
- R9: For a collapse state, enter ends only after `pwr_ack` is sampled low. Exit ends only after both `pwr_ack` and `cache_rdy` are sampled high. `core_rst` is 1 from enter through exit. `warm_boot` is a single-cycle pulse in the first run cycle after exit.
- R10: A `req_state` value of NSTATE or above uses the fields of state 0.
- R11: `timer_lost` rises when enter begins for a state with `cfg_timer_loss[i]`=1. It holds through idle and exit and is 0 again in the first run cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idle_req | input | 1 | Request to start a low-power episode, sampled in run |
| req_state | input | SW | Target state index, latched with the request |
| wake | input | 1 | Wake event |
| flush_done | input | 1 | Cache flush finished |
| pwr_ack | input | 1 | Power switch state: 1 when core power is present |
| cache_rdy | input | 1 | Caches and system ready after power return |
| cfg_entry_cyc | input | NSTATE*CW | Per-state minimum enter dwell, state i at bits i*CW |
| cfg_exit_cyc | input | NSTATE*CW | Per-state minimum exit dwell, state i at bits i*CW |
| cfg_collapse | input | NSTATE | Per-state 1 = power collapse, 0 = clock-gated retention |
| cfg_timer_loss | input | NSTATE | Per-state 1 = local timer lost |
| clk_gate | output | 1 | Core clock gated when 1 |
| pwr_en | output | 1 | Core power switch enable |
| core_rst | output | 1 | Core held in reset |
| warm_boot | output | 1 | One-cycle warm-boot release strobe |
| timer_lost | output | 1 | Local timer state lost in this episode |
| phase | output | 3 | Current phase code |

## Verification
Each configured state is run through a full episode, and so is one out-of-range index. The test records how many cycles each phase lasts. This separates retention states from collapse states: the length of prepare shows whether the flush handshake is awaited, and a warm-boot pulse appears only for collapse. The cases where the configured dwell is shorter or longer than the power-switch latency show whether the counter or the handshake ends a phase. Wake is applied zero and several cycles into idle, and is also raised early in prepare and in enter. These cases separate an abortable phase from a locked one. A late `cache_rdy` confirms that exit waits for the caches and not only for the counter.

// File: rtl/cidle_pkg.sv
package cidle_pkg;
   typedef enum logic [2:0] {
      PH_RUN   = 3'd0,
      PH_PREP  = 3'd1,
      PH_ENTRY = 3'd2,
      PH_IDLE  = 3'd3,
      PH_EXIT  = 3'd4
   } phase_e;
endpackage

// File: rtl/cidle_state_sel.sv
module cidle_state_sel #(
   parameter int NSTATE = 4,
   parameter int CW     = 8,
   parameter int SW     = 3
) (
   input  logic [SW-1:0]        idx,
   input  logic [NSTATE*CW-1:0] cfg_entry_cyc,
   input  logic [NSTATE*CW-1:0] cfg_exit_cyc,
   input  logic [NSTATE-1:0]    cfg_collapse,
   input  logic [NSTATE-1:0]    cfg_timer_loss,
   output logic [CW-1:0]        ent_cyc,
   output logic [CW-1:0]        ext_cyc,
   output logic                 collapse,
   output logic                 tmr_loss
);
   localparam logic [SW:0] NS_W = (SW+1)'(NSTATE);

   logic [CW-1:0] ent_arr [NSTATE];
   logic [CW-1:0] ext_arr [NSTATE];
   logic [SW-1:0] sel;

   generate
      if (NSTATE < 1 || NSTATE > (1 << SW)) begin : g_bad_nstate
         $error("cidle_state_sel: NSTATE must be in 1..2**SW");
      end
      if (CW < 1) begin : g_bad_cw
         $error("cidle_state_sel: CW must be at least 1");
      end
      for (genvar i = 0; i < NSTATE; i++) begin : g_unpack
         assign ent_arr[i] = cfg_entry_cyc[i*CW +: CW];
         assign ext_arr[i] = cfg_exit_cyc[i*CW +: CW];
      end
   endgenerate

   // indexes beyond the table fall back to the shallowest state
   assign sel = ({1'b0, idx} < NS_W) ? idx : '0;

   always_comb begin
      ent_cyc  = ent_arr[0];
      ext_cyc  = ext_arr[0];
      collapse = cfg_collapse[0];
      tmr_loss = cfg_timer_loss[0];
      for (int i = 1; i < NSTATE; i++) begin
         if (sel == SW'(i)) begin
            ent_cyc  = ent_arr[i];
            ext_cyc  = ext_arr[i];
            collapse = cfg_collapse[i];
            tmr_loss = cfg_timer_loss[i];
         end
      end
   end
endmodule

// File: rtl/cidle_dwell.sv
module cidle_dwell #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)             cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   // a phase loaded with N lasts max(N,1) cycles
   assign done = (cnt <= CW'(1));
endmodule

// File: rtl/cidle_seq.sv
module cidle_seq
   import cidle_pkg::*;
#(
   parameter int NSTATE = 4,
   parameter int CW     = 8,
   parameter int SW     = 3
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 idle_req,
   input  logic [SW-1:0]        req_state,
   input  logic                 wake,
   input  logic                 flush_done,
   input  logic                 pwr_ack,
   input  logic                 cache_rdy,
   input  logic [NSTATE*CW-1:0] cfg_entry_cyc,
   input  logic [NSTATE*CW-1:0] cfg_exit_cyc,
   input  logic [NSTATE-1:0]    cfg_collapse,
   input  logic [NSTATE-1:0]    cfg_timer_loss,
   output logic                 clk_gate,
   output logic                 pwr_en,
   output logic                 core_rst,
   output logic                 warm_boot,
   output logic                 timer_lost,
   output logic [2:0]           phase
);
   phase_e        ph, nxt;
   logic [SW-1:0] cur_idx;
   logic [CW-1:0] ent_cyc, ext_cyc;
   logic          st_col, st_tmr;
   logic          dwell_done, load_ent, load_ext;
   logic          wb_q, tmr_q;

   cidle_state_sel #(.NSTATE(NSTATE), .CW(CW), .SW(SW)) u_sel (
      .idx            (cur_idx),
      .cfg_entry_cyc  (cfg_entry_cyc),
      .cfg_exit_cyc   (cfg_exit_cyc),
      .cfg_collapse   (cfg_collapse),
      .cfg_timer_loss (cfg_timer_loss),
      .ent_cyc        (ent_cyc),
      .ext_cyc        (ext_cyc),
      .collapse       (st_col),
      .tmr_loss       (st_tmr)
   );

   cidle_dwell #(.CW(CW)) u_dwell (
      .clk      (clk),
      .rst      (rst),
      .load     (load_ent | load_ext),
      .load_val (load_ent ? ent_cyc : ext_cyc),
      .done     (dwell_done)
   );

   always_comb begin
      nxt = ph;
      unique case (ph)
         PH_RUN:   if (idle_req) nxt = PH_PREP;
         PH_PREP:  if (wake) nxt = PH_RUN;
                   else if (!st_col || flush_done) nxt = PH_ENTRY;
         PH_ENTRY: if (dwell_done && (!st_col || !pwr_ack)) nxt = PH_IDLE;
         PH_IDLE:  if (wake) nxt = PH_EXIT;
         PH_EXIT:  if (dwell_done && (!st_col || (pwr_ack && cache_rdy))) nxt = PH_RUN;
         default:  nxt = PH_RUN;
      endcase
   end

   assign load_ent = (ph == PH_PREP) && (nxt == PH_ENTRY);
   assign load_ext = (ph == PH_IDLE) && (nxt == PH_EXIT);

   always_ff @(posedge clk) begin
      if (rst) begin
         ph      <= PH_RUN;
         cur_idx <= '0;
         wb_q    <= 1'b0;
         tmr_q   <= 1'b0;
      end else begin
         ph   <= nxt;
         wb_q <= (ph == PH_EXIT) && (nxt == PH_RUN) && st_col;
         if ((ph == PH_RUN) && idle_req) cur_idx <= req_state;
         if ((ph == PH_EXIT) && (nxt == PH_RUN)) tmr_q <= 1'b0;
         else if (load_ent && st_tmr)            tmr_q <= 1'b1;
      end
   end

   assign clk_gate   = (ph == PH_ENTRY) || (ph == PH_IDLE) || (ph == PH_EXIT);
   assign pwr_en     = !(st_col && ((ph == PH_ENTRY) || (ph == PH_IDLE)));
   assign core_rst   = st_col && clk_gate;
   assign warm_boot  = wb_q;
   assign timer_lost = tmr_q;
   assign phase      = ph;
endmodule

// File: rtl/cidle_seq_chk.sv
module cidle_seq_chk (
   input logic       clk,
   input logic       rst,
   input logic       wake,
   input logic       flush_done,
   input logic       pwr_ack,
   input logic       cache_rdy,
   input logic       clk_gate,
   input logic       pwr_en,
   input logic       core_rst,
   input logic       warm_boot,
   input logic       timer_lost,
   input logic [2:0] phase
);
   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (phase == 3'd0 && pwr_en && !clk_gate && !core_rst && !warm_boot && !timer_lost));

   assert_prep_abort_R3: assert property (@(posedge clk) disable iff (rst)
      (phase == 3'd1 && wake) |=> (phase == 3'd0));

   assert_entry_locked_R4: assert property (@(posedge clk) disable iff (rst)
      (phase == 3'd2) |=> (phase == 3'd2 || phase == 3'd3));

   assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (phase == 3'd3 && !wake) |=> (phase == 3'd3));

   assert_idle_wake_R5: assert property (@(posedge clk) disable iff (rst)
      (phase == 3'd3 && wake) |=> (phase == 3'd4));

   assert_flush_before_cut_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(pwr_en) |-> $past(flush_done));

   assert_power_window_R8: assert property (@(posedge clk) disable iff (rst)
      !pwr_en |-> (phase == 3'd2 || phase == 3'd3));

   assert_warm_boot_cause_R9: assert property (@(posedge clk) disable iff (rst)
      warm_boot |-> (phase == 3'd0 && $past(phase) == 3'd4 && $past(cache_rdy) && $past(pwr_ack)));

   assert_warm_boot_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      warm_boot |=> !warm_boot);

   assert_timer_clear_R11: assert property (@(posedge clk) disable iff (rst)
      (phase == 3'd0 && $past(phase) == 3'd4) |-> !timer_lost);
endmodule

bind cidle_seq cidle_seq_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .wake       (wake),
   .flush_done (flush_done),
   .pwr_ack    (pwr_ack),
   .cache_rdy  (cache_rdy),
   .clk_gate   (clk_gate),
   .pwr_en     (pwr_en),
   .core_rst   (core_rst),
   .warm_boot  (warm_boot),
   .timer_lost (timer_lost),
   .phase      (phase)
);

// File: tb/sim_cidle_seq.sv
module sim_cidle_seq;
   localparam int CLK_PERIOD = 10;
   localparam int NSTATE = 4;
   localparam int CW = 8;
   localparam int SW = 3;
   localparam int FLUSH_LAT = 2;
   localparam int NV = 5;
   // {state[20:18], wake_delay[17:14], prep[13:10], enter[9:6], exit[5:2], warm_boot[1], timer[0]}
   localparam logic [20:0] VEC [NV] = '{
      {3'd0, 4'd2, 4'd1, 4'd3, 4'd2, 1'b0, 1'b0},
      {3'd1, 4'd0, 4'd1, 4'd1, 4'd5, 1'b0, 1'b1},
      {3'd2, 4'd3, 4'd2, 4'd4, 4'd2, 1'b1, 1'b1},
      {3'd3, 4'd1, 4'd2, 4'd2, 4'd6, 1'b1, 1'b0},
      {3'd5, 4'd0, 4'd1, 4'd3, 4'd2, 1'b0, 1'b0}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic idle_req = 1'b0;
   logic [SW-1:0] req_state = '0;
   logic wake = 1'b0;
   logic flush_done = 1'b0;
   logic pwr_ack = 1'b1;
   logic ack_d1 = 1'b1;
   logic cache_rdy = 1'b1;
   logic clk_gate, pwr_en, core_rst, warm_boot, timer_lost;
   logic [2:0] phase;
   int pcnt = 0;

   int n_chk = 0;
   int n_fail = 0;
   int r_np, r_ne, r_ni, r_nx, r_wb, r_wb_after, r_tmr_idle, r_pwr_idle, r_clkg_idle, r_rst_exit, r_tmr_end;

   always #(CLK_PERIOD/2) clk = ~clk;

   cidle_seq #(.NSTATE(NSTATE), .CW(CW), .SW(SW)) u0 (
      .clk(clk), .rst(rst), .idle_req(idle_req), .req_state(req_state), .wake(wake),
      .flush_done(flush_done), .pwr_ack(pwr_ack), .cache_rdy(cache_rdy),
      .cfg_entry_cyc({8'd1, 8'd4, 8'd0, 8'd3}),
      .cfg_exit_cyc ({8'd6, 8'd1, 8'd5, 8'd2}),
      .cfg_collapse (4'b1100),
      .cfg_timer_loss(4'b0110),
      .clk_gate(clk_gate), .pwr_en(pwr_en), .core_rst(core_rst), .warm_boot(warm_boot),
      .timer_lost(timer_lost), .phase(phase)
   );

   // neighbour models: flush engine and power switch with two-cycle acknowledge
   always @(negedge clk) begin
      if (phase == 3'd1) begin
         pcnt = pcnt + 1;
         flush_done = (pcnt >= FLUSH_LAT);
      end else begin
         pcnt = 0;
         flush_done = 1'b0;
      end
      pwr_ack = ack_d1;
      ack_d1 = pwr_en;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_one(input logic [SW-1:0] st, input int wdel, input bit early, input int rdy_hold);
      r_np = 0; r_ne = 0; r_ni = 0; r_nx = 0; r_wb = 0; r_wb_after = 0;
      r_tmr_idle = 0; r_pwr_idle = 1; r_clkg_idle = 0; r_rst_exit = 1; r_tmr_end = 0;
      @(negedge clk);
      idle_req = 1'b1;
      req_state = st;
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         idle_req = 1'b0;
         if (phase == 3'd0) begin
            r_wb = warm_boot;
            r_tmr_end = timer_lost;
            break;
         end
         case (phase)
            3'd1: r_np++;
            3'd2: begin
               r_ne++;
               if (early) wake = 1'b1;
            end
            3'd3: begin
               r_ni++;
               r_tmr_idle = timer_lost;
               r_pwr_idle = pwr_en;
               r_clkg_idle = clk_gate;
               if (r_ni > wdel) wake = 1'b1;
            end
            3'd4: begin
               wake = 1'b0;
               r_nx++;
               if (!core_rst) r_rst_exit = 0;
               if (rdy_hold > 0 && r_nx >= rdy_hold) cache_rdy = 1'b1;
            end
            default: ;
         endcase
      end
      @(negedge clk);
      r_wb_after = warm_boot;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1 phase", phase, 0);
      chk("R1 pwr_en", pwr_en, 1);
      chk("R1 clk_gate", clk_gate, 0);
      chk("R1 core_rst", core_rst, 0);
      chk("R1 warm_boot", warm_boot, 0);
      chk("R1 timer_lost", timer_lost, 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 phase after release", phase, 0);

      // table walk: R2 R5 R6 R7 R8 R9 R10 R11
      for (int v = 0; v < NV; v++) begin
         logic [20:0] e;
         e = VEC[v];
         run_one(e[20:18], int'(e[17:14]), 1'b0, 0);
         chk("R7/R8 prepare cycles", r_np, int'(e[13:10]));
         chk("R6/R9/R10 enter cycles", r_ne, int'(e[9:6]));
         chk("R5 idle cycles", r_ni, int'(e[17:14]) + 1);
         chk("R6/R9 exit cycles", r_nx, int'(e[5:2]));
         chk("R9 warm_boot pulse", r_wb, int'(e[1]));
         chk("R9 warm_boot one cycle", r_wb_after, 0);
         chk("R11 timer_lost in idle", r_tmr_idle, int'(e[0]));
         chk("R11 timer_lost cleared", r_tmr_end, 0);
         chk("R7/R8 pwr_en in idle", r_pwr_idle, int'(!e[1]));
         chk("R7 clk_gate in idle", r_clkg_idle, 1);
         chk("R2 back in run", phase, 0);
      end

      // R3: wake during prepare of a collapse state aborts it
      @(negedge clk);
      idle_req = 1'b1;
      req_state = 3'd2;
      @(negedge clk);
      idle_req = 1'b0;
      chk("R2 prepare after request", phase, 1);
      wake = 1'b1;
      @(negedge clk);
      wake = 1'b0;
      chk("R3 abort to run", phase, 0);
      chk("R3 power kept", pwr_en, 1);
      chk("R3 clock ungated", clk_gate, 0);
      chk("R3 timer untouched", timer_lost, 0);
      @(negedge clk);
      chk("R3 no warm boot", warm_boot, 0);

      // R4: wake held through enter neither shortens it nor skips idle
      run_one(3'd0, 0, 1'b1, 0);
      chk("R4 enter length with wake", r_ne, 3);
      chk("R4 idle reached once", r_ni, 1);
      chk("R4 exit length", r_nx, 2);

      // R9: exit of a collapse state waits for cache_rdy
      cache_rdy = 1'b0;
      run_one(3'd3, 1, 1'b0, 9);
      chk("R9 exit waits cache_rdy", r_nx, 9);
      chk("R9 core_rst through exit", r_rst_exit, 1);
      chk("R9 warm_boot after ready", r_wb, 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule